// File: doc/BRIEF.md
# Audio PWM Modulator With Symmetric Index Limit

This block turns a stream of signed 16-bit PCM samples into one single-ended pulse-width-modulated output. Each PWM period lasts 256 counter clocks. The high time at the start of each period follows the sample value in a straight line. Silence gives half duty. Large positive samples push the duty toward fully on, and large negative samples pull it toward fully off.

A downstream switching stage needs some off time in every period, and some on time as well, to recover. The block therefore clamps the duty between a programmable upper on-count and its mirror image at the bottom. After reset the upper on-count is 240 of 256 (93.75%). Software may write a lower value for stages that need more recovery time.

A new sample is taken only at a period boundary, so no pulse is cut short. A frame pulse marks each period start. A clip flag stays high for every period whose requested duty had to be clamped.

Top module: `apwm_mod_top`

## Requirements
- R1: A held sample of zero gives exactly 128 high cycles out of the 256-cycle period, with `clip_o` low.
- R2: The unclamped high count equals 128 plus the signed value of `in_sample[15:8]`. The eight low bits are dropped, so for example 0x4000 gives 192 and 0x00FF gives 128.
- R3: Negative samples give high counts below 128 by the same rule. The most negative code 0x8000 asks for 0 and is raised to the lower bound.
- R4: The high count never exceeds the limit L. After reset L is 240. A request above L produces exactly L.
- R5: The high count is never below 256 − L. A request below it produces exactly 256 − L, so every period starts high and ends low.
- R6: Pulsing `lim_we` for one cycle loads L from `lim_wdata`. A written value below 128 is stored as 128, which pins every period to 128 high cycles.
- R7: The period is 256 cycles. `frame_o` is high for exactly the first cycle of each period, and `pwm_o` is high for the first D cycles of the period, where D is the period's high count.
- R8: The sample (and L) used for a period is the one in place at the period boundary. A sample strobed in the last cycle of a period is used for the next period. A strobe in the middle of a period does not change that period. With no new strobe, the previous sample repeats.
- R9: `clip_o` is high for the whole of a period whose request was clamped and low for the whole of any other period. A request exactly equal to L or to 256 − L is not clamped.
- R10: While `rst_n` is low, `pwm_o` = 1, `frame_o` = 1 and `clip_o` = 0. Reset sets L to 240 and the held sample to zero, so the first period after release is the 50% idle pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Strobe: `in_sample` is a new sample |
| in_sample | input | 16 | Two's-complement PCM sample |
| lim_we | input | 1 | Write strobe for the limit register |
| lim_wdata | input | 8 | New upper on-count L (values below 128 are taken as 128) |
| pwm_o | output | 1 | PWM waveform |
| frame_o | output | 1 | High for the first cycle of each period |
| clip_o | output | 1 | High throughout a period whose duty was clamped |

## Verification
The bound checker keeps its own period counter and checks on every cycle that:
- `frame_o` lines up with the 256-cycle count;
- every period begins high and ends low, as the two clamps guarantee;
- `pwm_o` never rises inside a period;
- `clip_o` only changes at a frame boundary.

The bench's scenarios are the only way to show that the measured high count matches the linear mapping and the exact clamp values. They also cover the boundary cases that clamp or do not clamp, limit writes including the floor at 128, a mid-period strobe being deferred, sample repetition, and the restoring of the default limit by reset.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

  // Outcome of the duty clamp stage.
  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_HIGH = 2'd1,
    CLAMP_LOW  = 2'd2
  } clamp_kind_t;

  localparam int unsigned SAMPLE_W_DEF = 16;
  localparam int unsigned CNT_W_DEF    = 8;

endpackage

// File: rtl/apwm_limit_reg.sv
// Holds the upper on-count L and derives the mirrored lower bound 2^CNT_W - L.
module apwm_limit_reg #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned LIM_DEFAULT = (1 << CNT_W) - ((1 << CNT_W) / 16)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] lim_hi_o,
  output logic [CNT_W-1:0] lim_lo_o
);

  localparam logic [CNT_W-1:0] HALF    = CNT_W'(1 << (CNT_W - 1));
  localparam logic [CNT_W-1:0] LIM_RST = CNT_W'(LIM_DEFAULT);

  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_d;

  // A limit below half scale would invert the clamp window; floor it.
  always_comb begin
    lim_d = lim_q;
    if (wr_en) begin
      lim_d = (wr_data < HALF) ? HALF : wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= LIM_RST;
    end else if (wr_en) begin
      lim_q <= lim_d;
    end
  end

  assign lim_hi_o = lim_q;
  assign lim_lo_o = -lim_q;  // modulo 2^CNT_W, valid because lim_q >= HALF

endmodule

// File: rtl/apwm_duty_map.sv
// Maps a signed sample onto an offset-binary on-count and clamps it.
module apwm_duty_map
  import apwm_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNT_W    = 8
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [CNT_W-1:0]    lim_hi_i,
  input  logic [CNT_W-1:0]    lim_lo_i,
  output logic [CNT_W-1:0]    duty_o,
  output clamp_kind_t         kind_o
);

  localparam int unsigned DROP_W = SAMPLE_W - CNT_W;

  logic [CNT_W-1:0] s_hi;
  logic [CNT_W-1:0] raw_duty;

  assign s_hi = sample_i[SAMPLE_W-1 -: CNT_W];
  // Adding half scale to a two's-complement value is the same as flipping its sign bit.
  assign raw_duty = {~s_hi[CNT_W-1], s_hi[CNT_W-2:0]};

  generate
    if (DROP_W > 0) begin : g_drop
      logic unused_lsbs;
      assign unused_lsbs = ^sample_i[DROP_W-1:0];
    end
  endgenerate

  always_comb begin
    duty_o = raw_duty;
    kind_o = CLAMP_NONE;
    if (raw_duty > lim_hi_i) begin
      duty_o = lim_hi_i;
      kind_o = CLAMP_HIGH;
    end else if (raw_duty < lim_lo_i) begin
      duty_o = lim_lo_i;
      kind_o = CLAMP_LOW;
    end
  end

endmodule

// File: rtl/apwm_counter.sv
// Free-running period counter; flags the last cycle of each period.
module apwm_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             last_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;

  assign cnt_en    = 1'b1;
  assign cnt_nxt_o = cnt_en ? (cnt_q + ONE) : cnt_q;
  assign last_o    = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt_o;
    end
  end

endmodule

// File: rtl/apwm_out_stage.sv
// Period-latched duty and clip state, plus registered waveform and frame outputs.
module apwm_out_stage #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_new_i,
  input  logic             clip_new_i,
  output logic             pwm_o,
  output logic             frame_o,
  output logic             clip_o
);

  localparam logic [CNT_W-1:0] HALF = CNT_W'(1 << (CNT_W - 1));

  logic [CNT_W-1:0] duty_q, duty_d;
  logic             clip_q, clip_d;
  logic             pwm_q, pwm_d;
  logic             frame_q, frame_d;

  always_comb begin
    duty_d  = load_i ? duty_new_i : duty_q;
    clip_d  = load_i ? clip_new_i : clip_q;
    pwm_d   = (cnt_nxt_i < duty_d);
    frame_d = (cnt_nxt_i == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= HALF;
      clip_q <= 1'b0;
    end else if (load_i) begin
      duty_q <= duty_d;
      clip_q <= clip_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q   <= 1'b1;
      frame_q <= 1'b1;
    end else begin
      pwm_q   <= pwm_d;
      frame_q <= frame_d;
    end
  end

  assign pwm_o   = pwm_q;
  assign frame_o = frame_q;
  assign clip_o  = clip_q;

endmodule

// File: rtl/apwm_mod_top.sv
module apwm_mod_top
  import apwm_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = SAMPLE_W_DEF,
  parameter int unsigned CNT_W       = CNT_W_DEF,
  parameter int unsigned LIM_DEFAULT = (1 << CNT_W) - ((1 << CNT_W) / 16)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                lim_we,
  input  logic [CNT_W-1:0]    lim_wdata,
  output logic                pwm_o,
  output logic                frame_o,
  output logic                clip_o
);

  logic [SAMPLE_W-1:0] sample_q;
  logic [SAMPLE_W-1:0] sample_fresh;
  logic [CNT_W-1:0]    lim_hi, lim_lo;
  logic [CNT_W-1:0]    duty_new;
  clamp_kind_t         kind;
  logic [CNT_W-1:0]    cnt_nxt;
  logic                period_last;

  // Pending-sample hold; a strobe in the loading cycle is used at once.
  assign sample_fresh = in_valid ? in_sample : sample_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sample_q <= '0;
    end else if (in_valid) begin
      sample_q <= in_sample;
    end
  end

  apwm_limit_reg #(.CNT_W(CNT_W), .LIM_DEFAULT(LIM_DEFAULT)) u_limit (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (lim_we),
    .wr_data  (lim_wdata),
    .lim_hi_o (lim_hi),
    .lim_lo_o (lim_lo)
  );

  apwm_duty_map #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_map (
    .sample_i (sample_fresh),
    .lim_hi_i (lim_hi),
    .lim_lo_i (lim_lo),
    .duty_o   (duty_new),
    .kind_o   (kind)
  );

  apwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_nxt_o (cnt_nxt),
    .last_o    (period_last)
  );

  apwm_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_nxt_i  (cnt_nxt),
    .load_i     (period_last),
    .duty_new_i (duty_new),
    .clip_new_i (kind != CLAMP_NONE),
    .pwm_o      (pwm_o),
    .frame_o    (frame_o),
    .clip_o     (clip_o)
  );

endmodule

// File: rtl/apwm_mod_chk.sv
module apwm_mod_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic pwm_o,
  input logic frame_o,
  input logic clip_o
);

  logic [CNT_W-1:0] ck_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_cnt <= '0;
    end else begin
      ck_cnt <= ck_cnt + CNT_W'(1);
    end
  end

  // R7: frame pulse marks the first cycle of every 2^CNT_W-cycle period
  assert_frame_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o == (ck_cnt == '0));

  // R5: the lower clamp keeps at least one high cycle at period start
  assert_on_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> pwm_o);

  // R4: the upper clamp keeps the last cycle of each period low
  assert_off_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_cnt == '1) |-> !pwm_o);

  // R8: no second pulse inside a period
  assert_no_mid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_o && pwm_o) |-> $past(pwm_o));

  // R9: clip flag only changes at a period boundary
  assert_clip_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_o |-> $stable(clip_o));

endmodule

bind apwm_mod_top apwm_mod_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwm_o   (pwm_o),
  .frame_o (frame_o),
  .clip_o  (clip_o)
);

// File: tb/apwm_mod_top_tb_top.sv
`timescale 1ns/1ps
module apwm_mod_top_tb_top;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_sample;
  logic        lim_we;
  logic [7:0]  lim_wdata;
  logic        pwm_o, frame_o, clip_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  apwm_mod_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .lim_we    (lim_we),
    .lim_wdata (lim_wdata),
    .pwm_o     (pwm_o),
    .frame_o   (frame_o),
    .clip_o    (clip_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  // {limit, sample, expected high count, expected clip, requirement id}
  localparam int NV = 18;
  localparam logic [36:0] VEC [NV] = '{
    {8'd240, 16'h0000, 8'd128, 1'b0, 4'd1},
    {8'd240, 16'h7FFF, 8'd240, 1'b1, 4'd4},
    {8'd240, 16'h8000, 8'd16,  1'b1, 4'd3},
    {8'd240, 16'h4000, 8'd192, 1'b0, 4'd2},
    {8'd240, 16'hC000, 8'd64,  1'b0, 4'd3},
    {8'd240, 16'h7000, 8'd240, 1'b0, 4'd9},
    {8'd240, 16'h7100, 8'd240, 1'b1, 4'd4},
    {8'd240, 16'h9000, 8'd16,  1'b0, 4'd9},
    {8'd240, 16'h8F00, 8'd16,  1'b1, 4'd5},
    {8'd240, 16'h00FF, 8'd128, 1'b0, 4'd2},
    {8'd240, 16'hFFFF, 8'd127, 1'b0, 4'd3},
    {8'd192, 16'h4000, 8'd192, 1'b0, 4'd6},
    {8'd192, 16'h4100, 8'd192, 1'b1, 4'd6},
    {8'd192, 16'hBF00, 8'd64,  1'b1, 4'd5},
    {8'd100, 16'h4000, 8'd128, 1'b1, 4'd6},
    {8'd100, 16'h0000, 8'd128, 1'b0, 4'd6},
    {8'd255, 16'h7FFF, 8'd255, 1'b0, 4'd6},
    {8'd255, 16'h8000, 8'd1,   1'b1, 4'd5}
  };

  function automatic string rq_name(input int id);
    case (id)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic put_sample(input logic [15:0] s);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic put_limit(input logic [7:0] l);
    @(negedge clk);
    lim_we    = 1'b1;
    lim_wdata = l;
    @(negedge clk);
    lim_we    = 1'b0;
  endtask

  // Waits for the next period start, then measures one full period.
  // inj: strobe inj_s at cycle 100 of the measured period.
  task automatic measure(input int exp_d, input bit exp_c, input string rq,
                         input bit inj, input logic [15:0] inj_s);
    int hi = 0;
    int frames = 0;
    int clip_bad = 0;
    int guard = 0;
    while (!frame_o && guard < 600) begin
      @(negedge clk);
      guard++;
    end
    for (int i = 0; i < 256; i++) begin
      if (inj && i == 100) begin
        in_valid  = 1'b1;
        in_sample = inj_s;
      end
      if (inj && i == 101) in_valid = 1'b0;
      if (pwm_o) hi++;
      if (frame_o) frames++;
      if (clip_o !== exp_c) clip_bad++;
      if (i != 255) @(negedge clk);
    end
    check(rq, "high count", hi, exp_d);
    check(rq, "clip cycles wrong", clip_bad, 0);
    check("R7", "frames per period", frames, 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; lim_we = 1'b0; lim_wdata = '0;
    repeat (3) @(negedge clk);
    // R10: reset state of the outputs
    check("R10", "pwm in reset", int'(pwm_o), 1);
    check("R10", "frame in reset", int'(frame_o), 1);
    check("R10", "clip in reset", int'(clip_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 / R1: idle period after release is 50%
    measure(128, 1'b0, "R10", 1'b0, 16'h0);
    // R4: default limit 240 after reset
    put_sample(16'h7FFF);
    measure(240, 1'b1, "R4", 1'b0, 16'h0);

    for (int v = 0; v < NV; v++) begin
      put_limit(VEC[v][36:29]);
      put_sample(VEC[v][28:13]);
      measure(int'(VEC[v][12:5]), VEC[v][4], rq_name(int'(VEC[v][3:0])), 1'b0, 16'h0);
    end

    // R8: without a new strobe the previous sample repeats
    measure(1, 1'b1, "R8", 1'b0, 16'h0);

    // R8: mid-period strobe is deferred to the following period
    put_limit(8'd240);
    put_sample(16'h0000);
    measure(128, 1'b0, "R8", 1'b1, 16'h7FFF);
    @(negedge clk);
    measure(240, 1'b1, "R8", 1'b0, 16'h0);

    // R10: reset restores the default limit and the zero sample
    put_limit(8'd192);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    measure(128, 1'b0, "R10", 1'b0, 16'h0);
    put_sample(16'h7FFF);
    measure(240, 1'b1, "R10", 1'b0, 16'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule